// File: doc/BRIEF.md
# Flash Page Read Command Sequencer

This block reads one 16-byte page of on-chip user flash through the byte-wide command port of an embedded flash controller. It acts as a bus master with classic single-access handshakes. It plays back a fixed series of command frames against three registers of the controller: a control register, a transmit register and a receive register. A frame is opened by writing 0x80 to the control register. The opcode and operands are then written to the transmit register, and any data is read from the receive register. Writing 0x00 to the control register closes the frame.

A one-cycle start pulse carries a 14-bit page number. The sequencer then runs four stages in a fixed order: enable the configuration interface, load the page address, read the page, and finally disable the interface and put it in bypass. Between the enable stage and the next frame it waits a fixed time in microseconds, counted in clock cycles. It also leaves a short idle gap before the first data read. Each byte read from the page is presented with a one-cycle valid strobe. A done pulse marks the end of the run.

Top module: `flash_page_reader`

## Requirements
- R1: Control accesses use bus address 0x70, transmit accesses use 0x71 and receive accesses use 0x73. Writes drive we high and go only to 0x70 or 0x71. Reads drive we low and go only to 0x73.
- R2: After a start, the access list is exactly the following, with writes given as address/data. Enable stage: 70/80, 71/74, 71/08, 71/00, 71/00, 70/00. Address stage: 70/80, 71/B4, 71/00, 71/00, 71/00, 71/40, 71/00, 71/high, 71/low, 70/00. Read stage: 70/80, 71/CA, 71/10, 71/00, 71/01, then 16 reads of 73, then 70/00. Final stage: 70/80, 71/26, 71/00, 71/00, 70/00, 70/80, 71/FF four times, 70/80. That makes 49 accesses in all.
- R3: Every access holds stb, cyc, we, address and write data steady until ack. Stb is low for at least one cycle between any two accesses.
- R4: The gap between the acknowledge of the enable stage's closing write and the acknowledge of the next access is at least max(1, WAIT_US*CLK_MHZ) clock cycles longer than the gap between two back-to-back transmit writes.
- R5: The high page byte is {2'b00, page[13:8]} and the low page byte is page[7:0]. Both come from the page value sampled with the start pulse.
- R6: Exactly 16 byte_valid_o pulses occur per run. byte_o carries the 16 receive-register read values in the order they were read.
- R7: The gap before the first receive read exceeds the normal transmit-to-transmit gap by at least GAP_CYCLES cycles.
- R8: A start pulse while busy_o is high is ignored. It changes neither the access list, nor the page bytes, nor the number of runs.
- R9: done_o is a one-cycle pulse that comes after the acknowledge of the final 70/80 write. busy_o is low in the same cycle as done_o. No further access follows until the next start.
- R10: While rst_ni is low, and directly after it rises, busy_o, done_o, byte_valid_o, wb_cyc_o and wb_stb_o are low. A reset during a run aborts it, and the next start performs a complete run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| page_i | input | 14 | Page number, sampled with start |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| byte_valid_o | output | 1 | Page byte strobe |
| byte_o | output | 8 | Page byte |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_adr_o | output | 8 | Bus address |
| wb_dat_o | output | 8 | Bus write data |
| wb_dat_i | input | 8 | Bus read data |
| wb_ack_i | input | 1 | Bus acknowledge |

## Verification
If the step counter is wrong, the fault shows at the bus in the very next access: a wrong address, a wrong byte, or a missing or extra access in the 49-entry list. The bench compares every entry of that list. A wrong timer load shows only as a shortened or stretched gap after the enable frame or before the first read, so the bench measures both gaps against the ordinary transmit spacing. Faults in the handshake or state machine appear at the ports within a cycle or two. Examples are a strobe that does not drop after ack, a done pulse wider than one cycle or overlapping busy, and a restart taken while busy. Each of these is checked at several slave latencies.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  typedef enum logic [2:0] {OP_CTRL, OP_TX, OP_RX, OP_WAIT, OP_GAP} op_e;

  localparam logic [7:0] ADR_CTRL    = 8'h70;
  localparam logic [7:0] ADR_TX      = 8'h71;
  localparam logic [7:0] ADR_RX      = 8'h73;
  localparam logic [7:0] FRAME_OPEN  = 8'h80;
  localparam logic [7:0] FRAME_CLOSE = 8'h00;

  localparam int STEP_W     = 6;
  localparam int LAST_STEP  = 50;
  localparam int PAGE_BYTES = 16;
  localparam int RX_FIRST   = 23;
  localparam int RX_LAST    = RX_FIRST + PAGE_BYTES - 1;

  function automatic logic [7:0] op_addr(op_e op);
    case (op)
      OP_CTRL: op_addr = ADR_CTRL;
      OP_RX:   op_addr = ADR_RX;
      default: op_addr = ADR_TX;
    endcase
  endfunction
endpackage

// File: rtl/fpr_step_rom.sv
module fpr_step_rom
  import fpr_pkg::*;
#(
  parameter int PAGE_W = 14
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [PAGE_W-1:0] page_i,
  output op_e               op_o,
  output logic [7:0]        data_o
);
  logic [15:0] page_ext;
  assign page_ext = 16'(page_i);

  always_comb begin
    op_o   = OP_TX;
    data_o = 8'h00;
    if (int'(step_i) >= RX_FIRST && int'(step_i) <= RX_LAST) begin
      op_o = OP_RX;
    end else begin
      case (step_i)
        6'd0, 6'd7, 6'd17, 6'd40, 6'd45, 6'd50: begin
          op_o   = OP_CTRL;
          data_o = FRAME_OPEN;
        end
        6'd5, 6'd16, 6'd39, 6'd44: begin
          op_o   = OP_CTRL;
          data_o = FRAME_CLOSE;
        end
        6'd6:  op_o = OP_WAIT;
        6'd22: op_o = OP_GAP;
        6'd1:  data_o = 8'h74;
        6'd2:  data_o = 8'h08;
        6'd8:  data_o = 8'hB4;
        6'd12: data_o = 8'h40;
        6'd14: data_o = page_ext[15:8];
        6'd15: data_o = page_ext[7:0];
        6'd18: data_o = 8'hCA;
        6'd19: data_o = 8'h10;
        6'd21: data_o = 8'h01;
        6'd41: data_o = 8'h26;
        6'd46, 6'd47, 6'd48, 6'd49: data_o = 8'hFF;
        default: data_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/fpr_wb_access.sv
module fpr_wb_access #(
  parameter int ADR_W = 8,
  parameter int DAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [ADR_W-1:0] adr_i,
  input  logic [DAT_W-1:0] wdat_i,
  output logic             done_o,
  output logic [DAT_W-1:0] rdat_o,
  output logic             wb_cyc_o,
  output logic             wb_stb_o,
  output logic             wb_we_o,
  output logic [ADR_W-1:0] wb_adr_o,
  output logic [DAT_W-1:0] wb_dat_o,
  input  logic [DAT_W-1:0] wb_dat_i,
  input  logic             wb_ack_i
);
  typedef enum logic [1:0] {A_IDLE, A_ACTIVE, A_SPACE} acc_state_e;
  acc_state_e state_q;
  logic stb_q, we_q;
  logic [ADR_W-1:0] adr_q;
  logic [DAT_W-1:0] dat_q, rdat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= A_IDLE;
      stb_q   <= 1'b0;
      we_q    <= 1'b0;
      adr_q   <= '0;
      dat_q   <= '0;
      rdat_q  <= '0;
    end else begin
      case (state_q)
        A_IDLE: if (req_i) begin
          stb_q   <= 1'b1;
          we_q    <= we_i;
          adr_q   <= adr_i;
          dat_q   <= wdat_i;
          state_q <= A_ACTIVE;
        end
        A_ACTIVE: if (wb_ack_i) begin
          stb_q   <= 1'b0;
          we_q    <= 1'b0;
          rdat_q  <= wb_dat_i;
          state_q <= A_SPACE;
        end
        default: state_q <= A_IDLE;  // forced strobe-low cycle
      endcase
    end
  end

  assign done_o   = (state_q == A_SPACE);
  assign rdat_o   = rdat_q;
  assign wb_cyc_o = stb_q;
  assign wb_stb_o = stb_q;
  assign wb_we_o  = we_q;
  assign wb_adr_o = adr_q;
  assign wb_dat_o = dat_q;
endmodule

// File: rtl/fpr_timer.sv
module fpr_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/flash_page_reader.sv
module flash_page_reader
  import fpr_pkg::*;
#(
  parameter int CLK_MHZ    = 50,
  parameter int WAIT_US    = 5,
  parameter int GAP_CYCLES = 8,
  parameter int PAGE_W     = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              byte_valid_o,
  output logic [7:0]        byte_o,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic              wb_we_o,
  output logic [7:0]        wb_adr_o,
  output logic [7:0]        wb_dat_o,
  input  logic [7:0]        wb_dat_i,
  input  logic              wb_ack_i
);
  localparam int DELAY_RAW = WAIT_US * CLK_MHZ;
  localparam int DELAY_CYC = (DELAY_RAW < 1) ? 1 : DELAY_RAW;
  localparam int GAP_CYC   = (GAP_CYCLES < 1) ? 1 : GAP_CYCLES;
  localparam int TMR_MAX   = (DELAY_CYC > GAP_CYC) ? DELAY_CYC : GAP_CYC;
  localparam int TMR_W     = $clog2(TMR_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_ACCESS, S_TIMER} seq_state_e;

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic [PAGE_W-1:0] page_q;
  logic              done_q, bv_q;
  logic [7:0]        byte_q;

  op_e        cur_op;
  logic [7:0] cur_data;
  logic       is_access, acc_req, acc_done;
  logic [7:0] acc_rdat;
  logic       tmr_load, tmr_expired;
  logic [TMR_W-1:0] tmr_val;

  fpr_step_rom #(.PAGE_W(PAGE_W)) u_rom (
    .step_i (step_q),
    .page_i (page_q),
    .op_o   (cur_op),
    .data_o (cur_data)
  );

  assign is_access = (cur_op == OP_CTRL) || (cur_op == OP_TX) || (cur_op == OP_RX);
  assign acc_req   = (state_q == S_ISSUE) && is_access;
  assign tmr_load  = (state_q == S_ISSUE) && !is_access;
  assign tmr_val   = (cur_op == OP_WAIT) ? TMR_W'(DELAY_CYC) : TMR_W'(GAP_CYC);

  fpr_wb_access #(.ADR_W(8), .DAT_W(8)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (acc_req),
    .we_i     (cur_op != OP_RX),
    .adr_i    (op_addr(cur_op)),
    .wdat_i   (cur_data),
    .done_o   (acc_done),
    .rdat_o   (acc_rdat),
    .wb_cyc_o (wb_cyc_o),
    .wb_stb_o (wb_stb_o),
    .wb_we_o  (wb_we_o),
    .wb_adr_o (wb_adr_o),
    .wb_dat_o (wb_dat_o),
    .wb_dat_i (wb_dat_i),
    .wb_ack_i (wb_ack_i)
  );

  fpr_timer #(.CNT_W(TMR_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      page_q  <= '0;
      done_q  <= 1'b0;
      bv_q    <= 1'b0;
      byte_q  <= '0;
    end else begin
      done_q <= 1'b0;
      bv_q   <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          page_q  <= page_i;
          step_q  <= '0;
          state_q <= S_ISSUE;
        end
        S_ISSUE: state_q <= is_access ? S_ACCESS : S_TIMER;
        S_ACCESS: if (acc_done) begin
          if (cur_op == OP_RX) begin
            bv_q   <= 1'b1;
            byte_q <= acc_rdat;
          end
          if (int'(step_q) == LAST_STEP) begin
            done_q  <= 1'b1;
            step_q  <= '0;
            state_q <= S_IDLE;
          end else begin
            step_q  <= step_q + 1'b1;
            state_q <= S_ISSUE;
          end
        end
        default: if (tmr_expired) begin
          step_q  <= step_q + 1'b1;
          state_q <= S_ISSUE;
        end
      endcase
    end
  end

  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = done_q;
  assign byte_valid_o = bv_q;
  assign byte_o       = byte_q;
endmodule

// File: rtl/fpr_checker.sv
module fpr_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       done_o,
  input logic       byte_valid_o,
  input logic       wb_cyc_o,
  input logic       wb_stb_o,
  input logic       wb_we_o,
  input logic [7:0] wb_adr_o,
  input logic [7:0] wb_dat_o,
  input logic       wb_ack_i
);
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o && !wb_ack_i |=> wb_stb_o && wb_cyc_o && $stable(wb_adr_o) && $stable(wb_we_o) && $stable(wb_dat_o)); // R3
  AST_STB_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o && wb_ack_i |=> !wb_stb_o); // R3
  AST_ADR_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o |-> (wb_adr_o == 8'h70 || wb_adr_o == 8'h71 || wb_adr_o == 8'h73)); // R1
  AST_READ_RX_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o |-> (wb_we_o == (wb_adr_o != 8'h73))); // R1
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !wb_cyc_o && !wb_stb_o); // R10
  AST_BYTE_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> busy_o && !wb_stb_o); // R6
endmodule

bind flash_page_reader fpr_checker u_fpr_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .byte_valid_o (byte_valid_o),
  .wb_cyc_o     (wb_cyc_o),
  .wb_stb_o     (wb_stb_o),
  .wb_we_o      (wb_we_o),
  .wb_adr_o     (wb_adr_o),
  .wb_dat_o     (wb_dat_o),
  .wb_ack_i     (wb_ack_i)
);

// File: tb/flash_page_reader_bench.sv
`timescale 1ns/1ps
module flash_page_reader_bench;
  localparam int DELAY = 250;
  localparam int GAP   = 8;
  localparam int NACC  = 49;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [13:0] page = '0;
  logic busy, done, bv, cyc_o, stb, we;
  logic [7:0] byte_v, adr, dat_o;
  logic [7:0] dat_i = '0;
  logic ack = 1'b0;

  int checks = 0, errors = 0, cyc = 0;
  int lat = 0, lat_cnt = 0;
  logic [7:0] rd_cnt = '0;

  logic [7:0] log_adr [1024];
  logic [7:0] log_dat [1024];
  bit         log_we  [1024];
  int         log_cyc [1024];
  int         log_n = 0;
  logic [7:0] byte_log [256];
  int bn = 0, done_cnt = 0, done_busy_err = 0, done_wide_err = 0, gap_err = 0, done_cyc = 0;
  bit prev_hs = 0, prev_done = 0;

  always #10 clk = ~clk;

  flash_page_reader u_flash_page_reader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .page_i(page),
    .busy_o(busy), .done_o(done), .byte_valid_o(bv), .byte_o(byte_v),
    .wb_cyc_o(cyc_o), .wb_stb_o(stb), .wb_we_o(we), .wb_adr_o(adr),
    .wb_dat_o(dat_o), .wb_dat_i(dat_i), .wb_ack_i(ack)
  );

  function automatic logic [7:0] rx_val(input logic [7:0] n);
    return n * 8'd13 + 8'h5C;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      ack <= 1'b0;
      lat_cnt <= 0;
    end else if (stb && !ack) begin
      if (lat_cnt == lat) begin
        ack <= 1'b1;
        lat_cnt <= 0;
        if (!we) begin
          dat_i  <= rx_val(rd_cnt);
          rd_cnt <= rd_cnt + 8'd1;
        end
      end else lat_cnt <= lat_cnt + 1;
    end else ack <= 1'b0;
  end

  always @(negedge clk) begin
    if (prev_hs && stb) gap_err++;
    prev_hs = stb && ack;
    if (stb && ack) begin
      log_adr[log_n % 1024] = adr;
      log_we[log_n % 1024]  = we;
      log_dat[log_n % 1024] = we ? dat_o : dat_i;
      log_cyc[log_n % 1024] = cyc;
      log_n++;
    end
    if (bv) begin
      byte_log[bn % 256] = byte_v;
      bn++;
    end
    if (done) begin
      done_cnt++;
      done_cyc = cyc;
      if (busy) done_busy_err++;
      if (prev_done) done_wide_err++;
    end
    prev_done = done;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic exp_entry(input int i, input logic [13:0] pg, input logic [7:0] r0,
                           output logic [7:0] ea, output bit ew, output logic [7:0] ed);
    ew = 1; ea = 8'h71; ed = 8'h00;
    if (i >= 21 && i <= 36) begin
      ew = 0; ea = 8'h73; ed = rx_val(r0 + 8'(i - 21));
    end else begin
      case (i)
        0, 6, 16, 38, 43, 48: begin ea = 8'h70; ed = 8'h80; end
        5, 15, 37, 42:        begin ea = 8'h70; ed = 8'h00; end
        1: ed = 8'h74;
        2: ed = 8'h08;
        7: ed = 8'hB4;
        11: ed = 8'h40;
        13: ed = {2'b00, pg[13:8]};
        14: ed = pg[7:0];
        17: ed = 8'hCA;
        18: ed = 8'h10;
        20: ed = 8'h01;
        39: ed = 8'h26;
        44, 45, 46, 47: ed = 8'hFF;
        default: ed = 8'h00;
      endcase
    end
  endtask

  function automatic int li(input int n);
    return n % 1024;
  endfunction

  task automatic run_read(input logic [13:0] pg, input int latency, input bit restart);
    int l0, b0, d0, g0, e_adr, e_dat, e_pg, e_rd, first, t;
    logic [7:0] r0, ea, ed;
    bit ew;
    lat = latency;
    l0 = log_n; b0 = bn; d0 = done_cnt; g0 = gap_err; r0 = rd_cnt;
    e_adr = 0; e_dat = 0; e_pg = 0; e_rd = 0; first = -1;
    @(negedge clk); start = 1'b1; page = pg;
    @(negedge clk); start = 1'b0;
    if (restart) begin
      repeat (30) @(negedge clk);
      chk(busy == 1'b1, "R8 busy during run", busy, 1);
      start = 1'b1; page = ~pg;
      @(negedge clk); start = 1'b0;
      repeat (400) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (done_cnt == d0 && t < 20000) begin @(negedge clk); t++; end
    chk(done_cnt > d0, "R9 done reached", done_cnt - d0, 1);
    chk(done_busy_err == 0 && done_wide_err == 0, "R9 done one cycle, busy low", done_busy_err + done_wide_err, 0);
    chk(done_cyc > log_cyc[li(l0 + NACC - 1)], "R9 done after final write", done_cyc, log_cyc[li(l0 + NACC - 1)]);
    repeat (600) @(negedge clk);
    chk(done_cnt - d0 == 1, "R8 single run per start", done_cnt - d0, 1);
    chk(log_n - l0 == NACC, "R2 access count (R9 no trailing access)", log_n - l0, NACC);
    for (int i = 0; i < NACC; i++) begin
      exp_entry(i, pg, r0, ea, ew, ed);
      if (log_adr[li(l0 + i)] != ea || log_we[li(l0 + i)] != ew) begin
        if (e_adr == 0) first = i;
        e_adr++;
      end
      if (log_dat[li(l0 + i)] != ed) begin
        if (i == 13 || i == 14) e_pg++;
        else if (!ew) e_rd++;
        else e_dat++;
      end
    end
    chk(e_adr == 0, "R1 address/direction per access", first, -1);
    chk(e_dat == 0, "R2 write data list", e_dat, 0);
    chk(e_pg == 0, "R5 page bytes (R8 unchanged)", {log_dat[li(l0 + 13)], log_dat[li(l0 + 14)]},
        {2'b00, pg});
    chk(e_rd == 0, "R6 receive reads", e_rd, 0);
    chk(bn - b0 == 16, "R6 byte strobe count", bn - b0, 16);
    e_rd = 0;
    for (int k = 0; k < 16; k++)
      if (byte_log[(b0 + k) % 256] != rx_val(r0 + 8'(k))) e_rd++;
    chk(e_rd == 0, "R6 byte order and value", e_rd, 0);
    chk(gap_err == g0, "R3 strobe gap between accesses", gap_err - g0, 0);
    chk(log_cyc[li(l0 + 6)] - log_cyc[li(l0 + 5)] >=
        log_cyc[li(l0 + 4)] - log_cyc[li(l0 + 3)] + DELAY, "R4 enable wait",
        log_cyc[li(l0 + 6)] - log_cyc[li(l0 + 5)], DELAY);
    chk(log_cyc[li(l0 + 21)] - log_cyc[li(l0 + 20)] >=
        log_cyc[li(l0 + 19)] - log_cyc[li(l0 + 18)] + GAP, "R7 gap before first read",
        log_cyc[li(l0 + 21)] - log_cyc[li(l0 + 20)], GAP);
  endtask

  task automatic t_reset_state();
    chk({busy, done, bv, cyc_o, stb} == 5'b0, "R10 outputs in reset", {busy, done, bv, cyc_o, stb}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, bv, cyc_o, stb} == 5'b0, "R10 outputs after reset", {busy, done, bv, cyc_o, stb}, 0);
  endtask

  task automatic t_abort_reset();
    @(negedge clk); start = 1'b1; page = 14'h0123;
    @(negedge clk); start = 1'b0;
    repeat (300) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({busy, done, bv, cyc_o, stb} == 5'b0, "R10 abort clears outputs", {busy, done, bv, cyc_o, stb}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 idle after abort", busy, 0);
    run_read(14'h2C3A, 1, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    run_read(14'h0000, 0, 1'b0);
    run_read(14'h3FFF, 2, 1'b0);
    run_read(14'h01A5, 1, 1'b1);
    run_read(14'h2B5E, 3, 1'b0);
    t_abort_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule